// File: doc/BRIEF.md
# Saved-Carry Arithmetic Unit

This block is a 32-bit integer add/subtract engine that keeps a one-bit carry/borrow flag from one operation to the next. Each accepted operation takes a first operand from a source register value and a second operand that is either another register value or a small immediate. It produces a result tagged with a destination register index, for an external register file to write back. The persistent flag lets software chain several words of add or subtract into one wide operation, one word per cycle.

Six operations are offered: plain add, add with the saved carry, subtract, subtract with the saved borrow, and the two reverse subtracts, which take the first operand away from the second, with and without the saved borrow. An operation is issued for one cycle with `op_valid` high. Its result, index and write strobe appear registered on the next cycle. The flag is updated on the same clock edge.

Top module: `scarith_unit`

## Requirements
- R1: Code 0 (add) gives `wr_data = src1 + op2` modulo 2^32, and the flag becomes the carry out of bit 31.
- R2: Code 1 (add with carry) gives `src1 + op2 + flag`, and the flag becomes the new carry out.
- R3: Code 2 (subtract) gives `src1 - op2`, and the flag becomes 1 exactly when `op2 > src1` unsigned, meaning a borrow occurred.
- R4: Code 3 (subtract with borrow) gives `src1 - op2 - flag`, and the flag becomes 1 when that full difference is negative.
- R5: Code 4 (reverse subtract) gives `op2 - src1`, and the flag becomes 1 when `src1 > op2` unsigned.
- R6: Code 5 (reverse subtract with borrow) gives `op2 - src1 - flag`, and the flag becomes 1 when that difference is negative.
- R7: When `imm_sel` is 1, op2 is `imm_val` zero-extended to 32 bits and `src2_val` has no effect. When `imm_sel` is 0, op2 is `src2_val`.
- R8: For a valid legal operation at edge N, `wr_en` is 1 and `wr_idx`/`wr_data` carry its index and result after edge N+1. With no valid operation, `wr_en` is 0 after the next edge. Operations may be issued every cycle.
- R9: Reset, which is synchronous and active high, clears `wr_en` and the flag. The flag keeps its value across cycles with `op_valid` low.
- R10: Codes 6 and 7 are ignored even when `op_valid` is high: `wr_en` stays 0 and the flag is unchanged.
- R11: A 64-bit add done as code 0 then code 1, and a 64-bit subtract done as code 2 then code 3, issued back to back on the low and high words, give the correct 64-bit result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 3 | Operation code (0..5 legal) |
| src1_val | input | 32 | First operand register value |
| src2_val | input | 32 | Second operand register value |
| imm_val | input | 8 | Immediate for the second operand |
| imm_sel | input | 1 | 1 selects the immediate as second operand |
| dst_idx | input | 5 | Destination register index |
| wr_en | output | 1 | Writeback strobe |
| wr_idx | output | 5 | Writeback register index |
| wr_data | output | 32 | Writeback result |
| carry_q | output | 1 | Saved carry / borrow flag |

## Verification
The bench builds the unit with its defaults: 32-bit data, an 8-bit immediate and 5-bit indices. At 32 bits, the all-ones and sign-boundary operands bring carry and borrow out of the top bit within reach, and pairs of words give the 64-bit chaining cases. The 8-bit immediate makes 0xFF the widest zero-extension case. It also leaves the upper 24 bits of op2 to be checked as zero while `src2_val` carries all ones.

// File: rtl/scarith_pkg.sv
package scarith_pkg;

    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_IMM_W  = 8;
    localparam int unsigned DEF_IDX_W  = 5;
    localparam int unsigned CODE_W     = 3;

    typedef enum logic [CODE_W-1:0] {
        OPC_ADD = 3'd0,
        OPC_ADC = 3'd1,
        OPC_SUB = 3'd2,
        OPC_SUC = 3'd3,
        OPC_RSB = 3'd4,
        OPC_RSC = 3'd5
    } arith_op_e;

    typedef struct packed {
        logic legal;
        logic subtract;
        logic swap;
        logic use_flag;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input logic [CODE_W-1:0] code);
        op_ctl_t c;
        c.legal    = (code <= OPC_RSC);
        c.subtract = (code != OPC_ADD) && (code != OPC_ADC);
        c.swap     = code[2];
        c.use_flag = code[0];
        return c;
    endfunction

    // carry-in for the shared adder; a set borrow flag means "take one more away"
    function automatic logic adder_cin(input op_ctl_t c, input logic flag);
        if (c.subtract) return c.use_flag ? ~flag : 1'b1;
        return c.use_flag ? flag : 1'b0;
    endfunction

endpackage

// File: rtl/scarith_opsel.sv
module scarith_opsel #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 8
) (
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_sel,
    input  logic              swap,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] op2_dbg
);
    localparam int unsigned PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] op2;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb op2 = imm_sel ? {{PAD_W{1'b0}}, imm} : src2;
        end else begin : g_nopad
            always_comb op2 = imm_sel ? imm[DATA_W-1:0] : src2;
        end
    endgenerate

    always_comb begin
        opnd_a  = swap ? op2  : src1;
        opnd_b  = swap ? src1 : op2;
        op2_dbg = op2;
    end

    always_comb begin
        if (imm_sel) AST_IMM_LOW : assert (op2[IMM_W-1:0] == imm); // R7
    end
endmodule

// File: rtl/scarith_addsub.sv
module scarith_addsub #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              subtract,
    input  logic              cin,
    output logic [DATA_W-1:0] result,
    output logic              flag_next
);
    localparam int unsigned FULL_W = DATA_W + 1;

    logic [FULL_W-1:0] full;
    logic [DATA_W-1:0] b_eff;

    always_comb begin
        b_eff     = subtract ? ~opnd_b : opnd_b;
        full      = {1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        result    = full[DATA_W-1:0];
        flag_next = subtract ? ~full[DATA_W] : full[DATA_W];
    end
endmodule

// File: rtl/scarith_flag.sv
module scarith_flag (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic flag_next,
    output logic flag_q
);
    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (upd) flag_q <= flag_next;
    end

    AST_FLAG_RESET : assert property (@(posedge clk) rst |=> !flag_q); // R9
    AST_FLAG_HOLD  : assert property (@(posedge clk) disable iff (rst)
                                      !upd |=> $stable(flag_q)); // R10
endmodule

// File: rtl/scarith_unit.sv
module scarith_unit
    import scarith_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned IMM_W  = DEF_IMM_W,
    parameter int unsigned IDX_W  = DEF_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] src1_val,
    input  logic [DATA_W-1:0] src2_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              imm_sel,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              carry_q
);
    op_ctl_t           ctl;
    logic              accept;
    logic [DATA_W-1:0] opnd_a, opnd_b, op2_view, sum;
    logic              flag_nx, cin;

    always_comb begin
        ctl    = decode_op(op_code);
        accept = op_valid && ctl.legal;
        cin    = adder_cin(ctl, carry_q);
    end

    scarith_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .src1(src1_val), .src2(src2_val), .imm(imm_val), .imm_sel(imm_sel),
        .swap(ctl.swap), .opnd_a(opnd_a), .opnd_b(opnd_b), .op2_dbg(op2_view)
    );

    scarith_addsub #(.DATA_W(DATA_W)) u_addsub (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .subtract(ctl.subtract),
        .cin(cin), .result(sum), .flag_next(flag_nx)
    );

    scarith_flag u_flag (
        .clk(clk), .rst(rst), .upd(accept), .flag_next(flag_nx), .flag_q(carry_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= accept;
            if (accept) begin
                wr_idx  <= dst_idx;
                wr_data <= sum;
            end
        end
    end

    AST_WR_STROBE : assert property (@(posedge clk) disable iff (rst)
        accept |=> wr_en); // R8
    AST_WR_QUIET  : assert property (@(posedge clk) disable iff (rst)
        !accept |=> !wr_en); // R10
    AST_WR_INDEX  : assert property (@(posedge clk) disable iff (rst)
        accept |=> (wr_idx == $past(dst_idx))); // R8
    AST_ADD_SUM   : assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OPC_ADD) |=>
        ({carry_q, wr_data} == ({1'b0, $past(src1_val)} + {1'b0, $past(op2_view)}))); // R1
    AST_SUB_BORROW : assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OPC_SUB) |=>
        (carry_q == ($past(src1_val) < $past(op2_view)))); // R3
    AST_RSB_BORROW : assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OPC_RSB) |=>
        (carry_q == ($past(op2_view) < $past(src1_val)))); // R5
endmodule

// File: tb/scarith_unit_bench.sv
module scarith_unit_bench;
    localparam int CLK_P = 10;
    localparam int NV    = 24;

    // {op[3], imm_sel, a[32], b[32], imm[8], exp_data[32], exp_flag}
    localparam logic [108:0] VECS [0:NV-1] = '{
        {3'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 8'h00, 32'h00000000, 1'b1}, // R1
        {3'd1, 1'b0, 32'h00000000, 32'h00000000, 8'h00, 32'h00000001, 1'b0}, // R2
        {3'd0, 1'b0, 32'h00000007, 32'h00000008, 8'h00, 32'h0000000F, 1'b0}, // R1
        {3'd1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 8'h00, 32'hFFFFFFFF, 1'b0}, // R2
        {3'd0, 1'b0, 32'h80000000, 32'h80000000, 8'h00, 32'h00000000, 1'b1}, // R1
        {3'd1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h00, 32'hFFFFFFFF, 1'b1}, // R2
        {3'd2, 1'b0, 32'h00000005, 32'h00000003, 8'h00, 32'h00000002, 1'b0}, // R3
        {3'd2, 1'b0, 32'h00000003, 32'h00000005, 8'h00, 32'hFFFFFFFE, 1'b1}, // R3
        {3'd3, 1'b0, 32'h00000010, 32'h00000004, 8'h00, 32'h0000000B, 1'b0}, // R4
        {3'd3, 1'b0, 32'h00000000, 32'h00000000, 8'h00, 32'h00000000, 1'b0}, // R4
        {3'd2, 1'b0, 32'h00000000, 32'h00000001, 8'h00, 32'hFFFFFFFF, 1'b1}, // R3
        {3'd3, 1'b0, 32'h00000000, 32'h00000000, 8'h00, 32'hFFFFFFFF, 1'b1}, // R4
        {3'd4, 1'b0, 32'h00000003, 32'h00000005, 8'h00, 32'h00000002, 1'b0}, // R5
        {3'd4, 1'b0, 32'h00000005, 32'h00000003, 8'h00, 32'hFFFFFFFE, 1'b1}, // R5
        {3'd5, 1'b0, 32'h00000001, 32'h00000009, 8'h00, 32'h00000007, 1'b0}, // R6
        {3'd5, 1'b0, 32'h00000009, 32'h00000009, 8'h00, 32'h00000000, 1'b0}, // R6
        {3'd2, 1'b0, 32'h00000000, 32'h00000001, 8'h00, 32'hFFFFFFFF, 1'b1}, // R3
        {3'd5, 1'b0, 32'h00000000, 32'h00000000, 8'h00, 32'hFFFFFFFF, 1'b1}, // R6
        {3'd0, 1'b1, 32'h00000100, 32'hFFFFFFFF, 8'hFF, 32'h000001FF, 1'b0}, // R7
        {3'd2, 1'b1, 32'h00000000, 32'hFFFFFFFF, 8'h80, 32'hFFFFFF80, 1'b1}, // R7
        {3'd4, 1'b1, 32'h00000001, 32'hFFFFFFFF, 8'hFF, 32'h000000FE, 1'b0}, // R7
        {3'd2, 1'b0, 32'h00000000, 32'hFFFFFFFF, 8'h00, 32'h00000001, 1'b1}, // R3
        {3'd3, 1'b0, 32'h00000000, 32'hFFFFFFFF, 8'h00, 32'h00000000, 1'b1}, // R4
        {3'd1, 1'b0, 32'hFFFFFFFF, 32'h00000000, 8'h00, 32'h00000000, 1'b1}  // R2
    };

    logic        clk = 1'b0, rst = 1'b1, op_valid = 1'b0, imm_sel = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] src1_val = '0, src2_val = '0;
    logic [7:0]  imm_val = '0;
    logic [4:0]  dst_idx = '0;
    logic        wr_en, carry_q;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    int          checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    scarith_unit u_scarith_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .src1_val(src1_val), .src2_val(src2_val), .imm_val(imm_val),
        .imm_sel(imm_sel), .dst_idx(dst_idx), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .carry_q(carry_q)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic sel, input logic [31:0] a,
                         input logic [31:0] b, input logic [7:0] im, input logic [4:0] idx);
        op_valid = 1'b1; op_code = op; imm_sel = sel;
        src1_val = a; src2_val = b; imm_val = im; dst_idx = idx;
    endtask

    initial begin
        #(CLK_P * 20000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 reset wr_en", 64'(wr_en), 64'd0);
        chk("R9 reset flag", 64'(carry_q), 64'd0);

        // table walk, issued back to back (R8)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i][108:106], VECS[i][105], VECS[i][104:73], VECS[i][72:41],
                  VECS[i][40:33], 5'(i));
            @(negedge clk);
            chk($sformatf("R1-6 vec%0d data", i), 64'(wr_data), 64'(VECS[i][32:1]));
            chk($sformatf("vec%0d flag", i), 64'(carry_q), 64'(VECS[i][0]));
            chk($sformatf("R8 vec%0d strobe/idx", i), {58'd0, wr_en, wr_idx}, {58'd0, 1'b1, 5'(i)});
        end
        op_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle strobe", 64'(wr_en), 64'd0);
        chk("R9 idle hold flag", 64'(carry_q), 64'd1);

        // R10: illegal codes with flag at 1 and at 0
        drive(3'd6, 1'b0, 32'h0, 32'h0, 8'h0, 5'd3);
        @(negedge clk);
        chk("R10 code6 strobe", 64'(wr_en), 64'd0);
        chk("R10 code6 flag", 64'(carry_q), 64'd1);
        drive(3'd0, 1'b0, 32'h1, 32'h1, 8'h0, 5'd4);
        @(negedge clk);
        drive(3'd7, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'h0, 5'd5);
        @(negedge clk);
        chk("R10 code7 strobe", 64'(wr_en), 64'd0);
        chk("R10 code7 flag", 64'(carry_q), 64'd0);

        // R11: 64-bit add 0x1_FFFFFFFF + 0x2_00000001 = 0x4_00000000
        drive(3'd0, 1'b0, 32'hFFFFFFFF, 32'h00000001, 8'h0, 5'd10);
        @(negedge clk);
        chk("R11 add lo", 64'(wr_data), 64'h0);
        drive(3'd1, 1'b0, 32'h00000001, 32'h00000002, 8'h0, 5'd11);
        @(negedge clk);
        chk("R11 add hi", {31'd0, carry_q, wr_data}, 64'h0000_0000_0000_0004);
        // R11: 64-bit sub 0x5_00000000 - 0x1_00000001 = 0x3_FFFFFFFF
        drive(3'd2, 1'b0, 32'h00000000, 32'h00000001, 8'h0, 5'd12);
        @(negedge clk);
        chk("R11 sub lo", {31'd0, carry_q, wr_data}, 64'h0000_0001_FFFF_FFFF);
        drive(3'd3, 1'b0, 32'h00000005, 32'h00000001, 8'h0, 5'd13);
        @(negedge clk);
        chk("R11 sub hi", {31'd0, carry_q, wr_data}, 64'h0000_0000_0000_0003);

        // R9: reset clears a set flag
        drive(3'd2, 1'b0, 32'h0, 32'h1, 8'h0, 5'd1);
        @(negedge clk);
        op_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset clears flag", {62'd0, wr_en, carry_q}, 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule